// File: doc/BRIEF.md
# DDR4 Mode-Register Command Expander

This block sits between an initialization or feature-enable sequencer and the DRAM command path. It accepts one automatic mode-register write at a time. The request carries the register number, an 18-bit address value, a 2-bit bank address, a 2-bit bank group and a mask of target ranks. The block turns that request into a series of command beats on a valid/ready output. Each beat names its target ranks as a chip-select vector and states whether it is meant for the A side or the B side of a registered module.

On each beat the block applies three address fixes. First, odd ranks get the pair swaps used on mirrored modules. Next, B-side beats get the inverted copy that registered modules expect. Last, the reserved A17 and upper bank-group bits are cleared unless the configuration lets them through.

A 6-bit configuration word sets which fixes are active and whether ranks are addressed one at a time. The word can only be written while the controller-hold input is high. That input also flushes any expansion that is in progress.

Top module: `mrs_expander`

## Requirements
- R1: After reset, cmd_valid is 0, req_ready is 1 once hold is low, and the configuration is all zeros.
- R2: The configuration word loads from cfg_wdata when cfg_we and ctl_hold are both high. A write while ctl_hold is low has no effect. Its bits are: 0 per-rank staggering, 1 mirroring, 2 B-side inversion, 3 A17 pass, 4 BG1 pass, 5 BG-mirror disable.
- R3: While ctl_hold is high, req_ready is 0, and cmd_valid is 0 from the next cycle onward. Any expansion in progress is dropped.
- R4: With staggering on, one beat is sent per selected rank, in ascending rank order, with a one-hot cmd_cs. With staggering off, one beat per side is sent with cmd_cs equal to the rank mask and the ranks are treated as even.
- R5: With inversion on, each rank gets an A-side beat (cmd_bside=0) followed by a B-side beat (cmd_bside=1). The B-side beat inverts address bits 3 to 9, 11, 13 and 17, both bank-address bits and both bank-group bits. With inversion off, only A-side beats are sent.
- R6: With mirroring on and staggering on, beats to odd ranks swap address bits 3/4, 5/6, 7/8 and 11/13, bank-address bits 0/1 and bank-group bits 0/1. Beats to even ranks are not swapped.
- R7: With the BG-mirror disable bit set, the bank-group bits are not swapped on odd ranks. The other mirror pairs still swap.
- R8: With the A17 pass bit at 0, cmd_addr bit 17 is 0 on every beat.
- R9: With the BG1 pass bit at 0, cmd_bg bit 0 is cleared on mirrored odd-rank beats (mirroring on, BG-mirror disable off, odd rank). On all other beats cmd_bg bit 1 is cleared.
- R10: req_ready falls in the cycle after a request with a non-empty mask is accepted. It rises in the cycle after the last beat handshake.
- R11: While cmd_valid is high and cmd_ready is low (hold low), cmd_valid and all command fields stay unchanged.
- R12: A request with an empty rank mask is accepted, produces no beat, and leaves req_ready high.
- R13: cmd_mr equals the accepted register number, and address bits not named above pass through unchanged.

Mirroring is applied first, then inversion, then the masking of R8 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_hold | input | 1 | Controller held in reset: enables configuration writes and flushes expansion |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Configuration word |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_mr | input | MR_W (3) | Mode register number |
| req_addr | input | 18 | Mode register value |
| req_ba | input | 2 | Bank address |
| req_bg | input | 2 | Bank group |
| req_ranks | input | NRANK (4) | Target rank mask |
| cmd_valid | output | 1 | Command beat valid |
| cmd_ready | input | 1 | Command beat accepted downstream |
| cmd_cs | output | NRANK (4) | Chip-select vector of the beat |
| cmd_bside | output | 1 | 1 for a B-side beat |
| cmd_mr | output | MR_W (3) | Mode register number |
| cmd_addr | output | 18 | Transformed address |
| cmd_ba | output | 2 | Transformed bank address |
| cmd_bg | output | 2 | Transformed bank group |

## Verification
The hardest case is a single beat in which mirroring, B-side inversion and reserved-bit masking all apply together. This happens on the B-side beat of an odd rank when every enable is set. The pin that gets cleared then depends on whether the swap has already moved the reserved bank-group bit.

Random configurations make this overlap frequent across many address and bank patterns. One directed case also fixes an odd-rank beat by hand. Each beat is compared with a bench model that performs the swap, the inversion and the clearing as three separate steps. Random backpressure shows whether a final handshake and the release of req_ready line up in the right cycle.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int ADDR_W = 18;

  // Bit 5 down to bit 0 of the configuration word.
  typedef struct packed {
    logic bg_mirr_dis;
    logic bg1_pass;
    logic a17_pass;
    logic bside_inv;
    logic mirr_en;
    logic stagger;
  } mrs_cfg_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [1:0]        ba;
    logic [1:0]        bg;
  } mrs_bits_t;

  // Address bits flipped on B-side beats: 3..9, 11, 13, 17.
  localparam logic [ADDR_W-1:0] BSIDE_ADDR_FLIP = 18'h22BF8;
endpackage

// File: rtl/mrs_cfg_reg.sv
module mrs_cfg_reg
  import mrs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hold,
  input  logic     we,
  input  logic [5:0] wdata,
  output mrs_cfg_t cfg
);
  mrs_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (hold && we) cfg_d = mrs_cfg_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> $stable(cfg_q));
endmodule

// File: rtl/mrs_addr_xform.sv
module mrs_addr_xform
  import mrs_pkg::*;
(
  input  logic      mirr_en,
  input  logic      bg_mirr_dis,
  input  logic      a17_pass,
  input  logic      bg1_pass,
  input  logic      odd_rank,
  input  logic      bside,
  input  mrs_bits_t din,
  output mrs_bits_t dout
);
  mrs_bits_t mir, inv;
  logic      do_mirr;

  assign do_mirr = mirr_en && odd_rank;

  // Step 1: pair swaps on mirrored ranks.
  always_comb begin
    mir = din;
    if (do_mirr) begin
      mir.addr[3]  = din.addr[4];
      mir.addr[4]  = din.addr[3];
      mir.addr[5]  = din.addr[6];
      mir.addr[6]  = din.addr[5];
      mir.addr[7]  = din.addr[8];
      mir.addr[8]  = din.addr[7];
      mir.addr[11] = din.addr[13];
      mir.addr[13] = din.addr[11];
      mir.ba       = {din.ba[0], din.ba[1]};
      if (!bg_mirr_dis) mir.bg = {din.bg[0], din.bg[1]};
    end
  end

  // Step 2: B-side inversion.
  always_comb begin
    inv = mir;
    if (bside) begin
      inv.addr = mir.addr ^ BSIDE_ADDR_FLIP;
      inv.ba   = ~mir.ba;
      inv.bg   = ~mir.bg;
    end
  end

  // Step 3: clear reserved bits; the reserved bank-group bit follows the swap.
  always_comb begin
    dout = inv;
    if (!a17_pass) dout.addr[17] = 1'b0;
    if (!bg1_pass) begin
      if (do_mirr && !bg_mirr_dis) dout.bg[0] = 1'b0;
      else                         dout.bg[1] = 1'b0;
    end
  end
endmodule

// File: rtl/mrs_beat_seq.sv
module mrs_beat_seq #(
  parameter int NRANK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             stagger,
  input  logic             bside_inv,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [NRANK-1:0] req_ranks,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [NRANK-1:0] cmd_cs,
  output logic             cmd_bside,
  output logic             odd_rank
);
  localparam int RIDX_W = (NRANK > 1) ? $clog2(NRANK) : 1;

  logic             busy_q, busy_d;
  logic             side_q, side_d;
  logic [NRANK-1:0] rem_q, rem_d;
  logic [NRANK-1:0] low_oh;
  logic [RIDX_W-1:0] low_idx;

  assign low_oh = rem_q & (~rem_q + 1'b1);

  always_comb begin
    low_idx = '0;
    for (int i = NRANK - 1; i >= 0; i--) begin
      if (rem_q[i]) low_idx = RIDX_W'(i);
    end
  end

  assign cmd_valid = busy_q;
  assign req_ready = !busy_q && !hold;
  assign cmd_cs    = stagger ? low_oh : rem_q;
  assign cmd_bside = side_q;
  assign odd_rank  = stagger && low_idx[0];

  always_comb begin
    busy_d = busy_q;
    side_d = side_q;
    rem_d  = rem_q;
    if (hold) begin
      busy_d = 1'b0;
      side_d = 1'b0;
      rem_d  = '0;
    end else if (!busy_q) begin
      if (req_valid) begin
        rem_d  = req_ranks;
        busy_d = |req_ranks;
        side_d = 1'b0;
      end
    end else if (cmd_ready) begin
      if (bside_inv && !side_q) begin
        side_d = 1'b1;
      end else begin
        side_d = 1'b0;
        rem_d  = stagger ? (rem_q & ~low_oh) : '0;
        busy_d = |rem_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      side_q <= 1'b0;
      rem_q  <= '0;
    end else begin
      busy_q <= busy_d;
      side_q <= side_d;
      rem_q  <= rem_d;
    end
  end

  assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && stagger |-> $onehot(cmd_cs));
  assert_bside_only_inv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_bside |-> bside_inv);
  assert_hold_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !cmd_valid);
  assert_ready_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (|req_ranks) |=> !req_ready);
  assert_stall_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready && !hold |=>
      cmd_valid && $stable(cmd_cs) && $stable(cmd_bside));
endmodule

// File: rtl/mrs_expander.sv
module mrs_expander
  import mrs_pkg::*;
#(
  parameter int NRANK = 4,
  parameter int MR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_hold,
  input  logic              cfg_we,
  input  logic [5:0]        cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MR_W-1:0]   req_mr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_ba,
  input  logic [1:0]        req_bg,
  input  logic [NRANK-1:0]  req_ranks,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [NRANK-1:0]  cmd_cs,
  output logic              cmd_bside,
  output logic [MR_W-1:0]   cmd_mr,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [1:0]        cmd_ba,
  output logic [1:0]        cmd_bg
);
  // Asynchronous assert, synchronous release.
  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  mrs_cfg_t  cfg;
  mrs_bits_t pay_q, pay_d, xout;
  logic [MR_W-1:0] mr_q, mr_d;
  logic      accept, odd_rank;

  mrs_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_ni),
    .hold  (ctl_hold),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  mrs_beat_seq #(.NRANK(NRANK)) u_seq (
    .clk       (clk),
    .rst_n     (rst_ni),
    .hold      (ctl_hold),
    .stagger   (cfg.stagger),
    .bside_inv (cfg.bside_inv),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_ranks (req_ranks),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_cs    (cmd_cs),
    .cmd_bside (cmd_bside),
    .odd_rank  (odd_rank)
  );

  assign accept = req_valid && req_ready;

  always_comb begin
    pay_d = pay_q;
    mr_d  = mr_q;
    if (accept) begin
      pay_d = '{addr: req_addr, ba: req_ba, bg: req_bg};
      mr_d  = req_mr;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pay_q <= '0;
      mr_q  <= '0;
    end else begin
      pay_q <= pay_d;
      mr_q  <= mr_d;
    end
  end

  mrs_addr_xform u_xform (
    .mirr_en     (cfg.mirr_en),
    .bg_mirr_dis (cfg.bg_mirr_dis),
    .a17_pass    (cfg.a17_pass),
    .bg1_pass    (cfg.bg1_pass),
    .odd_rank    (odd_rank),
    .bside       (cmd_bside),
    .din         (pay_q),
    .dout        (xout)
  );

  assign cmd_mr   = mr_q;
  assign cmd_addr = xout.addr;
  assign cmd_ba   = xout.ba;
  assign cmd_bg   = xout.bg;

  assert_a17_clear_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    cmd_valid && !cfg.a17_pass |-> cmd_addr[17] == 1'b0);
  assert_payload_hold_R13: assert property (@(posedge clk) disable iff (!rst_ni)
    cmd_valid && !cmd_ready && !ctl_hold |=> $stable(cmd_addr) && $stable(cmd_mr));
endmodule

// File: tb/tb_mrs_expander.sv
module tb_mrs_expander;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_hold = 1'b0, cfg_we = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic req_valid = 1'b0, cmd_ready = 1'b0;
  logic req_ready, cmd_valid, cmd_bside;
  logic [2:0] req_mr = '0, cmd_mr;
  logic [17:0] req_addr = '0, cmd_addr;
  logic [1:0] req_ba = '0, req_bg = '0, cmd_ba, cmd_bg;
  logic [NR-1:0] req_ranks = '0, cmd_cs;

  always #4 clk = ~clk;

  mrs_expander #(.NRANK(NR), .MR_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_hold(ctl_hold), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_mr(req_mr), .req_addr(req_addr), .req_ba(req_ba), .req_bg(req_bg),
    .req_ranks(req_ranks), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_cs(cmd_cs), .cmd_bside(cmd_bside), .cmd_mr(cmd_mr),
    .cmd_addr(cmd_addr), .cmd_ba(cmd_ba), .cmd_bg(cmd_bg)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [5:0] cfg_m = '0;

  logic [NR-1:0] e_cs [16];
  bit            e_sd [16];
  logic [17:0]   e_ad [16];
  logic [1:0]    e_ba [16], e_bg [16];
  logic [17:0]   g_ad [16];
  logic [1:0]    g_bg [16];
  int nexp;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  // Model of one beat: swap, then invert, then clear.
  task automatic model(input logic [5:0] c, input bit odd, input bit bs,
                       input logic [17:0] a, input logic [1:0] ba, input logic [1:0] bg,
                       output logic [17:0] oa, output logic [1:0] oba, output logic [1:0] obg);
    logic [17:0] t; logic [1:0] tb, tg; bit m;
    t = a; tb = ba; tg = bg;
    m = c[1] && odd;
    if (m) begin
      t[3] = a[4]; t[4] = a[3]; t[5] = a[6]; t[6] = a[5];
      t[7] = a[8]; t[8] = a[7]; t[11] = a[13]; t[13] = a[11];
      tb = {ba[0], ba[1]};
      if (!c[5]) tg = {bg[0], bg[1]};
    end
    if (bs) begin
      for (int i = 3; i <= 9; i++) t[i] = ~t[i];
      t[11] = ~t[11]; t[13] = ~t[13]; t[17] = ~t[17];
      tb = ~tb; tg = ~tg;
    end
    if (!c[3]) t[17] = 1'b0;
    if (!c[4]) begin
      if (m && !c[5]) tg[0] = 1'b0; else tg[1] = 1'b0;
    end
    oa = t; oba = tb; obg = tg;
  endtask

  task automatic build(input logic [17:0] a, input logic [1:0] ba, input logic [1:0] bg,
                       input logic [NR-1:0] mask);
    nexp = 0;
    if (cfg_m[0]) begin
      for (int r = 0; r < NR; r++) if (mask[r])
        for (int s = 0; s <= int'(cfg_m[2]); s++) begin
          e_cs[nexp] = NR'(1 << r); e_sd[nexp] = bit'(s);
          model(cfg_m, bit'(r % 2), bit'(s), a, ba, bg, e_ad[nexp], e_ba[nexp], e_bg[nexp]);
          nexp++;
        end
    end else if (mask != 0) begin
      for (int s = 0; s <= int'(cfg_m[2]); s++) begin
        e_cs[nexp] = mask; e_sd[nexp] = bit'(s);
        model(cfg_m, 1'b0, bit'(s), a, ba, bg, e_ad[nexp], e_ba[nexp], e_bg[nexp]);
        nexp++;
      end
    end
  endtask

  task automatic set_cfg(input logic [5:0] v);
    @(negedge clk); ctl_hold = 1'b1; cfg_we = 1'b1; cfg_wdata = v; #1;
    chk(req_ready == 1'b0, "R3", "ready in hold", req_ready, 0);
    @(negedge clk); ctl_hold = 1'b0; cfg_we = 1'b0; #1;
    chk(cmd_valid == 1'b0, "R3", "valid after hold", cmd_valid, 0);
    cfg_m = v;
  endtask

  task automatic transact(input logic [2:0] mr, input logic [17:0] a, input logic [1:0] ba,
                          input logic [1:0] bg, input logic [NR-1:0] mask, input bit bp);
    int got = 0, cyc = 0; bit acc = 0, stall = 0;
    logic [NR-1:0] s_cs; bit s_sd; logic [17:0] s_ad;
    build(a, ba, bg, mask);
    @(negedge clk);
    req_valid = 1'b1; req_mr = mr; req_addr = a; req_ba = ba; req_bg = bg; req_ranks = mask;
    cmd_ready = bp ? 1'($urandom % 2) : 1'b1; #1;
    while (cyc < 300) begin
      if (acc && got < nexp)
        chk(req_ready == 1'b0, "R10", "ready while busy", req_ready, 0);
      if (acc && got == nexp) begin
        chk(req_ready == 1'b1 && cmd_valid == 1'b0, (nexp == 0) ? "R12" : "R10",
            "ready after last beat", {cmd_valid, req_ready}, 1);
        break;
      end
      if (stall) begin
        chk(cmd_valid && cmd_cs == s_cs && cmd_bside == s_sd && cmd_addr == s_ad,
            "R11", "stall stability", cmd_addr, s_ad);
        stall = 0;
      end
      if (cmd_valid) begin
        if (got >= nexp || !acc) begin
          chk(1'b0, "R4", "unexpected beat", cmd_cs, 0);
        end else if (cmd_ready) begin
          chk(cmd_cs == e_cs[got], "R4", "chip select", cmd_cs, e_cs[got]);
          chk(cmd_bside == e_sd[got], "R5", "side order", cmd_bside, e_sd[got]);
          chk(cmd_addr == e_ad[got], "R6", "address", cmd_addr, e_ad[got]);
          chk(cmd_ba == e_ba[got] && cmd_bg == e_bg[got], "R9", "bank bits",
              {cmd_ba, cmd_bg}, {e_ba[got], e_bg[got]});
          chk(cmd_mr == mr, "R13", "register number", cmd_mr, mr);
          g_ad[got] = cmd_addr; g_bg[got] = cmd_bg;
          got++;
        end else begin
          stall = 1; s_cs = cmd_cs; s_sd = cmd_bside; s_ad = cmd_addr;
        end
      end
      if (!acc && req_ready) acc = 1;
      @(negedge clk);
      if (acc) req_valid = 1'b0;
      cmd_ready = bp ? 1'($urandom % 2) : 1'b1; #1;
      cyc++;
    end
    if (cyc >= 300) chk(1'b0, "R10", "transaction timeout", got, nexp);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk); #1;
    chk(cmd_valid == 1'b0 && req_ready == 1'b1, "R1", "reset outputs", {cmd_valid, req_ready}, 1);
    // R1/R8/R9: zero configuration clears A17 and BG1
    transact(3'd2, 18'h3FFFF, 2'b11, 2'b11, 4'b0001, 0);
    chk(nexp == 1 && g_ad[0] == 18'h1FFFF && g_bg[0] == 2'b01, "R1", "zero-cfg beat", g_ad[0], 18'h1FFFF);
    // R2: write outside hold ignored
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 6'h3F;
    @(negedge clk); cfg_we = 1'b0;
    transact(3'd1, 18'h3FFFF, 2'b00, 2'b11, 4'b0110, 0);
    chk(nexp == 1, "R2", "ignored write", nexp, 1);
    // R6/R9 hand-fixed odd-rank beat
    set_cfg(6'b000011);
    transact(3'd0, 18'h00008, 2'b01, 2'b01, 4'b0010, 0);
    chk(g_ad[0] == 18'h00010 && g_bg[0] == 2'b10, "R6", "odd-rank swap", g_ad[0], 18'h10);
    // R7: BG mirror disabled
    set_cfg(6'b110011);
    transact(3'd3, 18'h02800, 2'b10, 2'b01, 4'b1010, 1);
    // R5 + R6 + R8 + R9 together
    set_cfg(6'b000111);
    transact(3'd4, 18'h2AAAA, 2'b01, 2'b01, 4'b1111, 1);
    // R12: empty mask
    transact(3'd5, 18'h00001, 2'b00, 2'b00, 4'b0000, 0);
    // R4: staggering off
    set_cfg(6'b011110);
    transact(3'd6, 18'h155F8, 2'b10, 2'b10, 4'b1011, 1);
    // R3: hold during a stalled expansion
    set_cfg(6'b000101);
    @(negedge clk); req_valid = 1'b1; req_ranks = 4'b1111; cmd_ready = 1'b0;
    @(negedge clk); req_valid = 1'b0; #1;
    chk(cmd_valid == 1'b1, "R3", "busy before hold", cmd_valid, 1);
    ctl_hold = 1'b1;
    @(negedge clk); #1;
    chk(cmd_valid == 1'b0 && req_ready == 1'b0, "R3", "flushed", {cmd_valid, req_ready}, 0);
    ctl_hold = 1'b0; #1;
    chk(req_ready == 1'b1, "R3", "ready after hold", req_ready, 1);
    // random mix
    for (int n = 0; n < 200; n++) begin
      if (n % 8 == 0) set_cfg(6'($urandom));
      transact(3'($urandom), 18'($urandom), 2'($urandom), 2'($urandom), NR'($urandom), bit'($urandom % 2));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule